// File: doc/BRIEF.md
# Enclave Instruction Fault Gate

This block sits beside the decode or execute stage of a processor core and decides the fate of a privileged enclave-management instruction at the moment it issues. It gathers the processor mode state, the platform feature-control bits, the virtualization guest controls with their per-leaf exit bitmap, the requested leaf number, the data segment type and any prefixes seen. From these it selects exactly one outcome: a transactional abort, an invalid-opcode fault, a VM exit, a general-protection fault with error code zero, or a dispatch to the leaf handler together with the leaf index.

The conditions are resolved in a fixed order of precedence, so the first matching condition alone sets the outcome. The outcome is registered: it appears one cycle after a request strobe, together with a one-cycle completion pulse, and is held until the next strobe. The set of supported leaves is a build-time mask parameter. The leaf handlers themselves live elsewhere.

Top module: `enclave_fault_gate`

## Requirements
- R1: While reset is low at a rising edge, the outcome becomes dispatch (code 0), the leaf index becomes 0 and the done flag becomes 0.
- R2: The outcome is a 3-bit code (0 dispatch, 1 transactional abort, 2 invalid opcode, 3 VM exit, 4 general protection). It is registered at the edge where req_valid is high and done is high for the next cycle. At an edge where req_valid is low, done goes low and the outcome and leaf index keep their values.
- R3: An active transactional region gives an abort, ahead of every other condition.
- R4: Protection disabled, the virtual-8086 flag set, system-management mode, or the enclave feature-present bit clear gives an invalid-opcode fault. This ranks above every condition except the abort.
- R5: A privilege level other than 0, or a LOCK, operand-size, REP or VEX prefix, gives an invalid-opcode fault. This ranks above the VM exit and all general-protection causes.
- R6: When guest_mode and exit_ctrl are both set, a leaf below 63 gives a VM exit if its own bitmap bit is set. A leaf of 63 or above, including leaves of 64 and more, gives a VM exit if bitmap bit 63 is set. The VM exit ranks above all general-protection causes. Without both controls set, the bitmap has no effect.
- R7: A clear feature-control lock bit or a clear feature-control enable bit gives a general-protection fault.
- R8: A leaf whose bit in VALID_LEAF_MASK is clear, or any leaf of 64 or above, gives a general-protection fault. Paging disabled also gives a general-protection fault.
- R9: Outside 64-bit mode, an expand-down data segment gives a general-protection fault. In 64-bit mode the segment type has no effect.
- R10: Only the low 32 bits of the leaf register are used, and bits 63..32 have no effect in any mode.
- R11: When no condition applies, the outcome is dispatch and leaf_idx carries the leaf number. For every other outcome leaf_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction issue strobe |
| txn_active | input | 1 | Transactional execution in progress |
| prot_en | input | 1 | Protection enabled |
| paging_en | input | 1 | Paging enabled |
| v86_flag | input | 1 | Virtual-8086 flag |
| smm_active | input | 1 | System-management mode |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 64-bit mode active |
| fc_lock | input | 1 | Feature-control lock bit |
| fc_enable | input | 1 | Feature-control enclave enable bit |
| feat_present | input | 1 | Enclave feature present |
| guest_mode | input | 1 | Virtualization non-root operation |
| exit_ctrl | input | 1 | Exit control for this instruction |
| exit_bitmap | input | 64 | Per-leaf exit bitmap |
| leaf_reg | input | 64 | Leaf number register |
| ds_expand_down | input | 1 | Data segment is expand-down |
| pfx_lock | input | 1 | LOCK prefix seen |
| pfx_opsize | input | 1 | Operand-size prefix seen |
| pfx_rep | input | 1 | REP prefix seen |
| pfx_vex | input | 1 | VEX prefix seen |
| outcome | output | 3 | Registered outcome code |
| leaf_idx | output | 6 | Leaf index on dispatch, else 0 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that every input is steady around the clock edge where req_valid is sampled. They also assume that a request arrives with a defined value on each mode and control pin, because the gate has no notion of a partly valid request. The stimulus keeps to this by changing inputs only at falling edges. It raises req_valid for whole cycles only, and starts every vector from a nominal state that dispatches, then flips only the pins that vector targets. This means each expected code follows from the order of precedence alone, and the abort assertion and the VM-exit assertion only ever see requests whose higher-ranked causes are known.

// File: rtl/efg_pkg.sv
// Package: shared outcome encoding for the enclave instruction fault gate.
// Assumes: consumers decode the 3-bit code exactly as listed here.
package efg_pkg;
    typedef enum logic [2:0] {
        OUT_DISPATCH = 3'd0,
        OUT_ABORT    = 3'd1,
        OUT_BADOP    = 3'd2,
        OUT_VMEXIT   = 3'd3,
        OUT_GPF      = 3'd4
    } outcome_e;
endpackage

// File: rtl/efg_mode_check.sv
// Module: efg_mode_check
// Finds the two invalid-opcode causes: a bad processor mode, and a bad
// privilege level or a forbidden prefix.
// Assumes: purely combinational; the caller applies precedence.
module efg_mode_check #(
    parameter int CPL_W = 2,
    parameter int PFX_N = 4
) (
    input  logic             prot_en,
    input  logic             v86_flag,
    input  logic             smm_active,
    input  logic             feat_present,
    input  logic [CPL_W-1:0] cpl,
    input  logic [PFX_N-1:0] pfx_seen,
    output logic             mode_bad,
    output logic             priv_bad
);
    // Mode cause: not protected, virtual-8086, SMM or feature absent.
    always_comb begin
        mode_bad = !prot_en || v86_flag || smm_active || !feat_present;
    end

    // Privilege cause: ring other than 0 or any forbidden prefix.
    always_comb begin
        priv_bad = (cpl != '0) || (|pfx_seen);
    end
endmodule

// File: rtl/efg_exit_check.sv
// Module: efg_exit_check
// Decides whether a guest request leaves to the hypervisor. Leaves below
// the top bitmap bit use their own bit; every higher leaf shares the top bit.
// Assumes: leaf_lo is the used part of the leaf register.
module efg_exit_check #(
    parameter int BITMAP_W    = 64,
    parameter int LEAF_USED_W = 32,
    localparam int IDX_W      = $clog2(BITMAP_W)
) (
    input  logic                   guest_mode,
    input  logic                   exit_ctrl,
    input  logic [LEAF_USED_W-1:0] leaf_lo,
    input  logic [BITMAP_W-1:0]    exit_bitmap,
    output logic                   exit_hit
);
    localparam int TOP_BIT = BITMAP_W - 1;

    logic             hi_zero;
    logic [IDX_W-1:0] idx;
    logic             below_top;
    logic             sel_bit;

    // Upper-bit test exists only when the leaf is wider than the index.
    generate
        if (LEAF_USED_W > IDX_W) begin : g_hi
            assign hi_zero = (leaf_lo[LEAF_USED_W-1:IDX_W] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign idx = leaf_lo[IDX_W-1:0];

    // Pick the bitmap bit governing this leaf.
    always_comb begin
        below_top = hi_zero && (int'(idx) < TOP_BIT);
        sel_bit   = below_top ? exit_bitmap[idx] : exit_bitmap[TOP_BIT];
    end

    // Exit only with guest operation and the exit control both on.
    always_comb begin
        exit_hit = guest_mode && exit_ctrl && sel_bit;
    end
endmodule

// File: rtl/efg_leaf_check.sv
// Module: efg_leaf_check
// Collects the general-protection causes: feature control, unsupported
// leaf, paging off and an expand-down data segment outside 64-bit mode.
// Assumes: VALID_LEAF_MASK has one bit per leaf below BITMAP_W.
module efg_leaf_check #(
    parameter int              BITMAP_W        = 64,
    parameter int              LEAF_USED_W     = 32,
    parameter logic [63:0]     VALID_LEAF_MASK = 64'h0000_0000_0000_01FF,
    localparam int             IDX_W           = $clog2(BITMAP_W)
) (
    input  logic                   fc_lock,
    input  logic                   fc_enable,
    input  logic                   paging_en,
    input  logic                   long_mode,
    input  logic                   ds_expand_down,
    input  logic [LEAF_USED_W-1:0] leaf_lo,
    output logic                   leaf_ok,
    output logic                   gp_hit
);
    logic             hi_zero;
    logic [IDX_W-1:0] idx;

    // Leaves at or beyond the mask width are never supported.
    generate
        if (LEAF_USED_W > IDX_W) begin : g_hi
            assign hi_zero = (leaf_lo[LEAF_USED_W-1:IDX_W] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign idx = leaf_lo[IDX_W-1:0];

    // Supported-leaf lookup in the build-time mask.
    always_comb begin
        leaf_ok = hi_zero && VALID_LEAF_MASK[idx];
    end

    // Any general-protection cause.
    always_comb begin
        gp_hit = !fc_lock || !fc_enable || !leaf_ok || !paging_en
                 || (!long_mode && ds_expand_down);
    end
endmodule

// File: rtl/enclave_fault_gate.sv
// Module: enclave_fault_gate (top)
// Resolves the outcome of a privileged enclave instruction by fixed
// precedence: abort, bad mode, bad privilege/prefix, VM exit, GP, dispatch.
// The result is registered on a request strobe and held otherwise.
// Assumes: inputs are stable around the edge where req_valid is high.
module enclave_fault_gate
    import efg_pkg::*;
#(
    parameter int          LEAF_REG_W      = 64,
    parameter int          LEAF_USED_W     = 32,
    parameter int          BITMAP_W        = 64,
    parameter int          CPL_W           = 2,
    parameter logic [63:0] VALID_LEAF_MASK = 64'h0000_0000_0000_01FF,
    localparam int         IDX_W           = $clog2(BITMAP_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  txn_active,
    input  logic                  prot_en,
    input  logic                  paging_en,
    input  logic                  v86_flag,
    input  logic                  smm_active,
    input  logic [CPL_W-1:0]      cpl,
    input  logic                  long_mode,
    input  logic                  fc_lock,
    input  logic                  fc_enable,
    input  logic                  feat_present,
    input  logic                  guest_mode,
    input  logic                  exit_ctrl,
    input  logic [BITMAP_W-1:0]   exit_bitmap,
    input  logic [LEAF_REG_W-1:0] leaf_reg,
    input  logic                  ds_expand_down,
    input  logic                  pfx_lock,
    input  logic                  pfx_opsize,
    input  logic                  pfx_rep,
    input  logic                  pfx_vex,
    output logic [2:0]            outcome,
    output logic [IDX_W-1:0]      leaf_idx,
    output logic                  done
);
    localparam int PFX_N = 4;

    logic [LEAF_USED_W-1:0] leaf_lo;
    logic                   leaf_hi_unused;
    logic                   mode_bad;
    logic                   priv_bad;
    logic                   exit_hit;
    logic                   gp_hit;
    logic                   leaf_ok;
    outcome_e               next_out;
    logic [IDX_W-1:0]       next_idx;

    // Only the low part of the leaf register takes part in any decision.
    assign leaf_lo        = leaf_reg[LEAF_USED_W-1:0];
    assign leaf_hi_unused = ^leaf_reg[LEAF_REG_W-1:LEAF_USED_W];

    efg_mode_check #(.CPL_W(CPL_W), .PFX_N(PFX_N)) u_mode (
        .prot_en      (prot_en),
        .v86_flag     (v86_flag),
        .smm_active   (smm_active),
        .feat_present (feat_present),
        .cpl          (cpl),
        .pfx_seen     ({pfx_lock, pfx_opsize, pfx_rep, pfx_vex}),
        .mode_bad     (mode_bad),
        .priv_bad     (priv_bad)
    );

    efg_exit_check #(.BITMAP_W(BITMAP_W), .LEAF_USED_W(LEAF_USED_W)) u_exit (
        .guest_mode  (guest_mode),
        .exit_ctrl   (exit_ctrl),
        .leaf_lo     (leaf_lo),
        .exit_bitmap (exit_bitmap),
        .exit_hit    (exit_hit)
    );

    efg_leaf_check #(
        .BITMAP_W        (BITMAP_W),
        .LEAF_USED_W     (LEAF_USED_W),
        .VALID_LEAF_MASK (VALID_LEAF_MASK)
    ) u_leaf (
        .fc_lock        (fc_lock),
        .fc_enable      (fc_enable),
        .paging_en      (paging_en),
        .long_mode      (long_mode),
        .ds_expand_down (ds_expand_down),
        .leaf_lo        (leaf_lo),
        .leaf_ok        (leaf_ok),
        .gp_hit         (gp_hit)
    );

    // Fixed-precedence choice of the outcome and its leaf index.
    always_comb begin
        next_idx = '0;
        if (txn_active)       next_out = OUT_ABORT;
        else if (mode_bad)    next_out = OUT_BADOP;
        else if (priv_bad)    next_out = OUT_BADOP;
        else if (exit_hit)    next_out = OUT_VMEXIT;
        else if (gp_hit)      next_out = OUT_GPF;
        else begin
            next_out = OUT_DISPATCH;
            next_idx = leaf_lo[IDX_W-1:0];
        end
    end

    // Outcome register: load on a strobe, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outcome  <= OUT_DISPATCH;
            leaf_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= req_valid;
            if (req_valid) begin
                outcome  <= next_out;
                leaf_idx <= next_idx;
            end
        end
    end

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && $stable(outcome) && $stable(leaf_idx))); // R2
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        outcome <= 3'd4); // R2
    AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && txn_active) |=> (outcome == OUT_ABORT)); // R3
    AST_MODE_BADOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !txn_active && mode_bad) |=> (outcome == OUT_BADOP)); // R4
    AST_EXIT_OVER_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !txn_active && !mode_bad && !priv_bad && exit_hit)
        |=> (outcome == OUT_VMEXIT)); // R6
    AST_EXIT_NEEDS_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
        exit_hit |-> (guest_mode && exit_ctrl)); // R6
    AST_IDX_ON_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome != OUT_DISPATCH) |-> (leaf_idx == '0)); // R11
endmodule

// File: tb/enclave_fault_gate_test.sv
module enclave_fault_gate_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] TB_MASK    = 64'h8000_0000_0000_00F7;

    // Deviation flags from a nominal dispatching request.
    localparam logic [15:0] F_TXN  = 16'h0001;
    localparam logic [15:0] F_NOPE = 16'h0002;
    localparam logic [15:0] F_NOPG = 16'h0004;
    localparam logic [15:0] F_V86  = 16'h0008;
    localparam logic [15:0] F_SMM  = 16'h0010;
    localparam logic [15:0] F_LM   = 16'h0020;
    localparam logic [15:0] F_NOLK = 16'h0040;
    localparam logic [15:0] F_NOEN = 16'h0080;
    localparam logic [15:0] F_NOFT = 16'h0100;
    localparam logic [15:0] F_GST  = 16'h0200;
    localparam logic [15:0] F_CTL  = 16'h0400;
    localparam logic [15:0] F_DSED = 16'h0800;
    localparam logic [15:0] F_PLK  = 16'h1000;
    localparam logic [15:0] F_POSZ = 16'h2000;
    localparam logic [15:0] F_PREP = 16'h4000;
    localparam logic [15:0] F_PVEX = 16'h8000;

    localparam logic [63:0] B0 = 64'h0;
    localparam logic [63:0] BX = 64'h8000_0000_0000_0010;
    localparam logic [63:0] B6 = 64'h0000_0000_0000_0040;

    typedef struct packed {
        logic [15:0] fl;
        logic [1:0]  cpl;
        logic [63:0] leaf;
        logic [63:0] bmap;
        logic [2:0]  eo;
        logic [5:0]  el;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VT [NV] = '{
        '{16'h0,            2'd0, 64'd0,   B0, 3'd0, 6'd0,  4'd11}, // R11
        '{16'h0,            2'd0, 64'd5,   B0, 3'd0, 6'd5,  4'd11}, // R11
        '{F_LM,             2'd0, 64'd63,  B0, 3'd0, 6'd63, 4'd11}, // R11
        '{F_TXN|F_NOPE|F_V86|F_NOLK, 2'd3, 64'd3, BX, 3'd1, 6'd0, 4'd3}, // R3
        '{F_NOPE,           2'd0, 64'd0,   B0, 3'd2, 6'd0,  4'd4},  // R4
        '{F_V86,            2'd0, 64'd0,   B0, 3'd2, 6'd0,  4'd4},  // R4
        '{F_SMM,            2'd0, 64'd0,   B0, 3'd2, 6'd0,  4'd4},  // R4
        '{F_NOFT|F_NOLK,    2'd0, 64'd0,   B0, 3'd2, 6'd0,  4'd4},  // R4
        '{16'h0,            2'd1, 64'd0,   B0, 3'd2, 6'd0,  4'd5},  // R5
        '{F_PREP|F_GST|F_CTL, 2'd0, 64'd4, BX, 3'd2, 6'd0,  4'd5},  // R5
        '{F_PVEX,           2'd0, 64'd0,   B0, 3'd2, 6'd0,  4'd5},  // R5
        '{F_PLK,            2'd0, 64'd0,   B0, 3'd2, 6'd0,  4'd5},  // R5
        '{F_POSZ|F_NOPG,    2'd0, 64'd0,   B0, 3'd2, 6'd0,  4'd5},  // R5
        '{F_GST|F_CTL|F_NOLK, 2'd0, 64'd4, BX, 3'd3, 6'd0,  4'd6},  // R6
        '{F_GST|F_CTL,      2'd0, 64'd5,   BX, 3'd0, 6'd5,  4'd6},  // R6
        '{F_GST|F_CTL,      2'd0, 64'd100, BX, 3'd3, 6'd0,  4'd6},  // R6
        '{F_GST,            2'd0, 64'd4,   BX, 3'd0, 6'd4,  4'd6},  // R6
        '{F_CTL,            2'd0, 64'd4,   BX, 3'd0, 6'd4,  4'd6},  // R6
        '{F_GST|F_CTL,      2'd0, 64'd70,  B6, 3'd4, 6'd0,  4'd6},  // R6
        '{F_GST|F_CTL,      2'd0, 64'd63,  BX, 3'd3, 6'd0,  4'd6},  // R6
        '{F_NOLK,           2'd0, 64'd0,   B0, 3'd4, 6'd0,  4'd7},  // R7
        '{F_NOEN,           2'd0, 64'd0,   B0, 3'd4, 6'd0,  4'd7},  // R7
        '{16'h0,            2'd0, 64'd3,   B0, 3'd4, 6'd0,  4'd8},  // R8
        '{16'h0,            2'd0, 64'd64,  B0, 3'd4, 6'd0,  4'd8},  // R8
        '{F_NOPG,           2'd0, 64'd0,   B0, 3'd4, 6'd0,  4'd8},  // R8
        '{16'h0,            2'd0, 64'h8000_0001, B0, 3'd4, 6'd0, 4'd8}, // R8
        '{F_DSED,           2'd0, 64'd0,   B0, 3'd4, 6'd0,  4'd9},  // R9
        '{F_DSED|F_LM,      2'd0, 64'd1,   B0, 3'd0, 6'd1,  4'd9},  // R9
        '{F_LM,             2'd0, 64'hFFFF_FFFF_0000_0005, B0, 3'd0, 6'd5, 4'd10}, // R10
        '{F_GST|F_CTL,      2'd0, 64'hABCD_0000_0000_0004, BX, 3'd3, 6'd0, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        txn_active, prot_en, paging_en, v86_flag, smm_active;
    logic [1:0]  cpl;
    logic        long_mode, fc_lock, fc_enable, feat_present;
    logic        guest_mode, exit_ctrl, ds_expand_down;
    logic [63:0] exit_bitmap, leaf_reg;
    logic        pfx_lock, pfx_opsize, pfx_rep, pfx_vex;
    logic [2:0]  outcome;
    logic [5:0]  leaf_idx;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enclave_fault_gate #(.VALID_LEAF_MASK(TB_MASK)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .txn_active(txn_active), .prot_en(prot_en), .paging_en(paging_en),
        .v86_flag(v86_flag), .smm_active(smm_active), .cpl(cpl),
        .long_mode(long_mode), .fc_lock(fc_lock), .fc_enable(fc_enable),
        .feat_present(feat_present), .guest_mode(guest_mode),
        .exit_ctrl(exit_ctrl), .exit_bitmap(exit_bitmap), .leaf_reg(leaf_reg),
        .ds_expand_down(ds_expand_down), .pfx_lock(pfx_lock),
        .pfx_opsize(pfx_opsize), .pfx_rep(pfx_rep), .pfx_vex(pfx_vex),
        .outcome(outcome), .leaf_idx(leaf_idx), .done(done)
    );

    task automatic drive(input vec_t v);
        txn_active     = |(v.fl & F_TXN);
        prot_en        = ~|(v.fl & F_NOPE);
        paging_en      = ~|(v.fl & F_NOPG);
        v86_flag       = |(v.fl & F_V86);
        smm_active     = |(v.fl & F_SMM);
        long_mode      = |(v.fl & F_LM);
        fc_lock        = ~|(v.fl & F_NOLK);
        fc_enable      = ~|(v.fl & F_NOEN);
        feat_present   = ~|(v.fl & F_NOFT);
        guest_mode     = |(v.fl & F_GST);
        exit_ctrl      = |(v.fl & F_CTL);
        ds_expand_down = |(v.fl & F_DSED);
        pfx_lock       = |(v.fl & F_PLK);
        pfx_opsize     = |(v.fl & F_POSZ);
        pfx_rep        = |(v.fl & F_PREP);
        pfx_vex        = |(v.fl & F_PVEX);
        cpl            = v.cpl;
        leaf_reg       = v.leaf;
        exit_bitmap    = v.bmap;
    endtask

    task automatic check(input string tag, input logic [2:0] eo,
                         input logic [5:0] el, input logic ed);
        checks++;
        if (outcome !== eo || leaf_idx !== el || done !== ed) begin
            fails++;
            $display("FAIL %s: outcome=%0d leaf=%0d done=%0b expected outcome=%0d leaf=%0d done=%0b",
                     tag, outcome, leaf_idx, done, eo, el, ed);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        drive(VT[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", 3'd0, 6'd0, 1'b0);

        // Table walk: strobe one cycle, sample the next falling edge.
        for (int i = 0; i < NV; i++) begin
            drive(VT[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R%0d vector %0d", VT[i].rq, i), VT[i].eo, VT[i].el, 1'b1);
        end

        // R2: done is a single pulse; idle input changes do not move outputs.
        drive(VT[1]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drive(VT[3]);
        @(negedge clk);
        check("R2 done drops, outcome held", 3'd0, 6'd5, 1'b0);
        repeat (3) @(negedge clk);
        check("R2 hold over idle cycles", 3'd0, 6'd5, 1'b0);

        // R2: back-to-back strobes update every cycle.
        drive(VT[20]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R2 back-to-back first", 3'd4, 6'd0, 1'b1);
        drive(VT[2]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 back-to-back second", 3'd0, 6'd63, 1'b1);

        // R1: reset in mid-run clears a fault outcome, even with a strobe.
        drive(VT[4]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R4 before reset", 3'd2, 6'd0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears outcome", 3'd0, 6'd0, 1'b0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stays clear after reset", 3'd0, 6'd0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule